// File: doc/BRIEF.md
# Single-Wire Bus Master Engine

This block drives a single-wire, open-drain bus from a synchronous system. On a command it runs one of three bus operations: a reset pulse followed by a check for a device answer, the transmission of one byte, or the reception of one byte. The line is never driven high. The block either pulls the line low through `bus_oe`, or it releases the line so that an external pull-up can raise it. The level of the line comes back on `bus_in`.

All bus timing counts in microsecond ticks. A divider makes these ticks from the system clock, using the `CLK_HZ` parameter. Every duration is a tick count parameter, with defaults in the usual range for this kind of bus: reset low 480, presence wait 70, reset tail 430, slot opening 6, read sample point 10, slot body 64 and recovery 5.

A host pulses `start` with an operation code, and with a byte on `wdata` when it writes. It then waits for the single-cycle `done`. After a read it takes the byte from `rdata`. After a reset it reads the answer from `presence`.

Top module: `ow_master`

## Requirements
- R1: After reset `bus_oe`, `busy`, `done`, `presence` and `rdata` are all 0.
- R2: Operation code 2'b00 (bus reset) drives `bus_oe` high for exactly T_RST_LOW ticks, starting at the edge that accepts the command. It then releases the line.
- R3: T_PRES ticks after the reset pulse ends, the synchronised line level is sampled. `presence` becomes 1 if the line was low and 0 if it was high. The value is cleared when a new reset command is accepted, and otherwise holds through later writes and reads.
- R4: A reset command finishes T_RST_TAIL ticks after the presence sample. `done` is high for exactly one cycle, in the first cycle in which `busy` is low.
- R5: Operation code 2'b01 (write) sends `wdata` least significant bit first, in 8 slots of T_SLOT+T_REC ticks each. A slot drives `bus_oe` high for T_LOW ticks when the bit is 1 and for T_SLOT ticks when the bit is 0. The line stays released for the rest of the slot.
- R6: Operation code 2'b10 (read) runs 8 slots of the same length. Each slot drives the line low for T_LOW ticks and samples the synchronised line T_SAMP ticks after the slot starts. Bits fill `rdata` least significant bit first. `rdata` updates only when a read finishes.
- R7: One tick lasts CLK_HZ/1,000,000 clock cycles, and the tick divider restarts on each accepted command. A reset therefore keeps `busy` high for exactly (T_RST_LOW+T_PRES+T_RST_TAIL)·DIV cycles, and a byte operation for exactly 8·(T_SLOT+T_REC)·DIV cycles.
- R8: A `start` while `busy` is high has no effect on the running operation, its timing or its data. A `start` carrying operation code 2'b11 is ignored and leaves `busy` and `bus_oe` low.
- R9: `busy` rises at the edge that accepts a command and stays high until the edge that raises `done`.
- R10: A `start` sampled in the cycle in which `done` is high is accepted and begins a new operation at once.
- R11: While `busy` is low, `bus_oe` is low, so the line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe |
| op | input | 2 | Operation code: 00 reset, 01 write, 10 read, 11 none |
| wdata | input | 8 | Byte to transmit |
| rdata | output | 8 | Last byte received |
| presence | output | 1 | 1 when a device answered the last reset |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_oe | output | 1 | 1 pulls the line low, 0 releases it |
| bus_in | input | 1 | Line level as seen at the pin |

## Verification
Completion of one operation and acceptance of the next can fall in the same cycle. While `done` is high the engine is already idle, so a `start` raised in that cycle must launch the next command with no lost cycle. The bench provokes this by raising `start` as soon as it sees `done`. It judges the result by requiring `busy` to be high one cycle later and the new operation's busy time to be exactly the computed length. A second overlap, a `start` in the middle of a running write, is judged at the ports by the decoded slot widths and the unchanged total duration.

// File: rtl/ow_pkg.sv
package ow_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NONE  = 2'b11
  } ow_op_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RST_LOW  = 3'd1,
    ST_RST_WAIT = 3'd2,
    ST_RST_TAIL = 3'd3,
    ST_SLOT     = 3'd4
  } ow_state_e;

  // clock cycles in one microsecond tick, never below one
  function automatic int clocks_per_us(input int clk_hz);
    int d;
    d = clk_hz / 1_000_000;
    return (d < 1) ? 1 : d;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // ticks the line stays low inside one bit slot
  function automatic int low_ticks(input ow_op_e kind, input logic bit_val,
                                   input int t_open, input int t_body);
    return (kind == OP_WRITE && !bit_val) ? t_body : t_open;
  endfunction

endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr || cnt == LAST) cnt <= '0;
    else                         cnt <= cnt + W'(1);
  end

  assign tick = (cnt == LAST) && !clr;
endmodule

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (!rst_n) ff <= {STAGES{RST_VAL}};
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/ow_shift.sv
module ow_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {sin, q[W-1:1]};
  end
endmodule

// File: rtl/ow_master.sv
module ow_master
  import ow_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int T_RST_LOW  = 480,
  parameter int T_PRES     = 70,
  parameter int T_RST_TAIL = 430,
  parameter int T_LOW      = 6,
  parameter int T_SAMP     = 10,
  parameter int T_SLOT     = 64,
  parameter int T_REC      = 5,
  parameter int BITS       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic [BITS-1:0] wdata,
  output logic [BITS-1:0] rdata,
  output logic            presence,
  output logic            busy,
  output logic            done,
  output logic            bus_oe,
  input  logic            bus_in
);
  localparam int DIV      = clocks_per_us(CLK_HZ);
  localparam int SLOT_LEN = T_SLOT + T_REC;
  localparam int MAX_T    = max_of(max_of(T_RST_LOW, T_RST_TAIL), max_of(T_PRES, SLOT_LEN));
  localparam int CNT_W    = $clog2(MAX_T + 1);
  localparam int IDX_W    = $clog2(BITS);

  ow_state_e        state;
  ow_op_e           op_q;
  logic [CNT_W-1:0] us_cnt, seg_end, rel_end;
  logic [IDX_W-1:0] bit_idx;
  logic [BITS-1:0]  sr_q, rdata_q;
  logic             oe_q, pres_q, done_q;

  // named internal events
  logic tick, line_s, accept, seg_last, pres_ev, slot_end, sample_ev, rel_ev;
  logic fin_ev, last_bit, sr_shift, sr_in;

  ow_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(accept), .tick(tick)
  );

  ow_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(line_s)
  );

  ow_shift #(.W(BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(wdata),
    .shift(sr_shift), .sin(sr_in), .q(sr_q)
  );

  assign accept = start && (state == ST_IDLE) && (ow_op_e'(op) != OP_NONE);

  always_comb begin
    case (state)
      ST_RST_LOW:  seg_end = CNT_W'(T_RST_LOW - 1);
      ST_RST_WAIT: seg_end = CNT_W'(T_PRES - 1);
      ST_RST_TAIL: seg_end = CNT_W'(T_RST_TAIL - 1);
      ST_SLOT:     seg_end = CNT_W'(SLOT_LEN - 1);
      default:     seg_end = '0;
    endcase
  end

  assign rel_end   = CNT_W'(low_ticks(op_q, sr_q[0], T_LOW, T_SLOT) - 1);
  assign seg_last  = (state != ST_IDLE) && tick && (us_cnt == seg_end);
  assign pres_ev   = (state == ST_RST_WAIT) && seg_last;
  assign slot_end  = (state == ST_SLOT) && seg_last;
  assign rel_ev    = (state == ST_SLOT) && tick && (us_cnt == rel_end);
  assign sample_ev = (state == ST_SLOT) && (op_q == OP_READ) && tick &&
                     (us_cnt == CNT_W'(T_SAMP - 1));
  assign last_bit  = (bit_idx == IDX_W'(BITS - 1));
  assign fin_ev    = ((state == ST_RST_TAIL) && seg_last) || (slot_end && last_bit);
  assign sr_shift  = ((op_q == OP_WRITE) && slot_end) || sample_ev;
  assign sr_in     = (op_q == OP_READ) ? line_s : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= OP_RESET;
      us_cnt  <= '0;
      bit_idx <= '0;
      oe_q    <= 1'b0;
      pres_q  <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= fin_ev;

      if (accept || seg_last)                us_cnt <= '0;
      else if (tick && state != ST_IDLE)     us_cnt <= us_cnt + CNT_W'(1);

      if (accept)        bit_idx <= '0;
      else if (slot_end) bit_idx <= bit_idx + IDX_W'(1);

      if (accept)                                oe_q <= 1'b1;
      else if (state == ST_RST_LOW && seg_last)  oe_q <= 1'b0;
      else if (slot_end && !last_bit)            oe_q <= 1'b1;
      else if (rel_ev)                           oe_q <= 1'b0;

      if (accept && ow_op_e'(op) == OP_RESET) pres_q <= 1'b0;
      else if (pres_ev)                       pres_q <= ~line_s;

      if (fin_ev && op_q == OP_READ) rdata_q <= sr_q;

      case (state)
        ST_IDLE: if (accept) begin
          op_q  <= ow_op_e'(op);
          state <= (ow_op_e'(op) == OP_RESET) ? ST_RST_LOW : ST_SLOT;
        end
        ST_RST_LOW:  if (seg_last) state <= ST_RST_WAIT;
        ST_RST_WAIT: if (seg_last) state <= ST_RST_TAIL;
        ST_RST_TAIL: if (seg_last) state <= ST_IDLE;
        ST_SLOT:     if (slot_end && last_bit) state <= ST_IDLE;
        default:     state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = done_q;
  assign bus_oe   = oe_q;
  assign presence = pres_q;
  assign rdata    = rdata_q;
endmodule

// File: rtl/ow_master_chk.sv
module ow_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] op_in,
  input logic [1:0] op_q,
  input logic       busy,
  input logic       done,
  input logic       bus_oe,
  input logic       presence,
  input logic       accept,
  input logic       slot_end,
  input logic       pres_ev,
  input logic       fin_ev
);
  p_idle_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_oe);

  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin_ev) |=> busy);

  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(op_q));

  p_low_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(accept || slot_end));

  p_presence_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pres_ev && !(accept && op_in == 2'b00)) |=> $stable(presence));
endmodule

bind ow_master ow_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_in(op), .op_q(op_q),
  .busy(busy), .done(done), .bus_oe(bus_oe), .presence(presence),
  .accept(accept), .slot_end(slot_end), .pres_ev(pres_ev), .fin_ev(fin_ev)
);

// File: tb/ow_master_tb.sv
module ow_master_tb;
  localparam int DIV = 8;               // bench clock treated as 8 MHz for tick purposes
  localparam int TR_LOW = 480, TR_PRES = 70, TR_TAIL = 430;
  localparam int TS_LOW = 6, TS_SLOT = 64, TS_REC = 5;
  localparam int RST_CYC  = (TR_LOW + TR_PRES + TR_TAIL) * DIV;
  localparam int BYTE_CYC = 8 * (TS_SLOT + TS_REC) * DIV;

  logic clk = 1'b0;
  logic rst_n, start;
  logic [1:0] op;
  logic [7:0] wdata, rdata;
  logic presence, busy, done, bus_oe, bus_in;
  logic slave_pull = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  assign bus_in = ~(bus_oe | slave_pull);

  ow_master #(.CLK_HZ(8_000_000)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wdata(wdata),
    .rdata(rdata), .presence(presence), .busy(busy), .done(done),
    .bus_oe(bus_oe), .bus_in(bus_in)
  );

  typedef struct {
    logic [1:0] kind;
    int         cycles;
    logic       pres;
    logic [7:0] rd;
    logic [7:0] wb;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_fail = 0;
  int slave_mode = 0;          // 0 passive, 1 answer reset, 2 send byte
  logic [7:0] slave_byte = 8'h00;
  logic [2:0] slave_idx = 3'd0;
  logic exp_pres = 1'b0;
  logic [7:0] exp_rd = 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural device on the line
  initial begin
    forever begin
      @(posedge bus_oe);
      if (slave_mode == 1) begin
        @(negedge bus_oe);
        repeat (120) @(negedge clk);
        slave_pull = 1'b1;
        repeat (800) @(negedge clk);
        slave_pull = 1'b0;
      end else if (slave_mode == 2) begin
        if (!slave_byte[slave_idx]) begin
          slave_pull = 1'b1;
          repeat (240) @(negedge clk);
          slave_pull = 1'b0;
        end
        slave_idx = slave_idx + 3'd1;
      end
    end
  end

  // monitor: decodes slots and compares each finished operation
  initial begin
    int cyc, run, rst_run;
    logic [7:0] wbits;
    exp_t it;
    cyc = 0; run = 0; rst_run = 0; wbits = 8'h00;
    forever begin
      @(negedge clk);
      if (bus_oe) run++;
      else if (run > 0) begin
        if (run == TS_LOW * DIV)       wbits = {1'b1, wbits[7:1]};
        else if (run == TS_SLOT * DIV) wbits = {1'b0, wbits[7:1]};
        else                           rst_run = run;
        run = 0;
      end
      if (busy) cyc++;
      if (done) begin
        if (sb.size() == 0) check(0, "R8 unexpected done", 1, 0);
        else begin
          it = sb.pop_front();
          check(cyc == it.cycles, "R7 busy duration", cyc, it.cycles);
          check(presence == it.pres, "R3 presence", presence, it.pres);
          check(rdata == it.rd, "R6 rdata", rdata, it.rd);
          if (it.kind == 2'b00) check(rst_run == TR_LOW * DIV, "R2 reset low width", rst_run, TR_LOW * DIV);
          if (it.kind == 2'b01) check(wbits == it.wb, "R5 written byte", wbits, it.wb);
        end
        cyc = 0; wbits = 8'h00; rst_run = 0;
      end
    end
  end

  // driver: called at a falling edge, pushes the expectation and strobes start
  task automatic issue(input logic [1:0] k, input logic [7:0] d, input int smode, input logic [7:0] sbyte);
    exp_t it;
    it.kind = k;
    it.cycles = (k == 2'b00) ? RST_CYC : BYTE_CYC;
    if (k == 2'b00) exp_pres = (smode == 1);
    if (k == 2'b10) exp_rd = sbyte;
    it.pres = exp_pres; it.rd = exp_rd; it.wb = d;
    sb.push_back(it);
    slave_mode = smode; slave_byte = sbyte; slave_idx = 3'd0;
    start = 1'b1; op = k; wdata = d;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy after accept", busy, 1);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 2'b00; wdata = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(bus_oe == 1'b0, "R1 bus_oe", bus_oe, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(presence == 1'b0, "R1 presence", presence, 0);
    check(rdata == 8'h00, "R1 rdata", rdata, 0);

    // reset with a device answering
    issue(2'b00, 8'h00, 1, 8'h00);
    wait_done();
    @(negedge clk);

    // write with a stray start in the middle (R8)
    issue(2'b01, 8'hA5, 0, 8'h00);
    repeat (1000) @(negedge clk);
    start = 1'b1; op = 2'b10; wdata = 8'h00;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8 busy kept", busy, 1);
    wait_done();
    @(negedge clk);

    // read a pattern
    issue(2'b10, 8'h00, 2, 8'h3C);
    wait_done();
    @(negedge clk);

    // operation code 11 is ignored (R8)
    start = 1'b1; op = 2'b11;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b0, "R8 code 11 busy", busy, 0);
    repeat (20) @(negedge clk);
    check(bus_oe == 1'b0, "R8 code 11 line released", bus_oe, 0);
    check(busy == 1'b0, "R8 code 11 still idle", busy, 0);

    // reset with no device, then back-to-back commands on done (R10)
    issue(2'b00, 8'h00, 0, 8'h00);
    wait_done();
    issue(2'b01, 8'h01, 0, 8'h00);
    check(busy == 1'b1, "R10 start on done accepted", busy, 1);
    wait_done();
    issue(2'b10, 8'h00, 2, 8'hFF);
    check(busy == 1'b1, "R10 read on done accepted", busy, 1);
    wait_done();
    issue(2'b01, 8'h80, 0, 8'h00);
    wait_done();
    issue(2'b10, 8'h00, 2, 8'h00);
    wait_done();
    @(negedge clk);
    check(done == 1'b0, "R4 done one cycle", done, 0);
    check(bus_oe == 1'b0, "R11 released when idle", bus_oe, 0);
    check(sb.size() == 0, "R4 all operations finished", sb.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule